// File: doc/BRIEF.md
# Capture Timebase Counter with Compare and Reload

This block is the free-running time reference of an input-capture unit. A 24-bit register counts upward once per prescaled tick. The tick comes from one of four sources: the system clock itself, or the rising edge of one of three capture-channel signals, each brought through a two-flop synchronizer. A divider with eight ratios, including the irregular /96 and /112, then thins the tick stream. Counting happens only while the run control is high.

A compare register is checked against the value an increment is about to produce. A hit raises a one-cycle match pulse and can optionally restart the count at zero. Capture-event pulses from the channels can also restart the count at zero. A reload path copies the compare value into the counter on a selected trigger, either one capture channel or a natural wrap. A wrap from all-ones to zero raises a one-cycle overflow pulse. A direct write from the bus side places a value in the counter on the next edge and restarts the prescaler phase. Flag storage, the register interface and the capture channels themselves belong to the surrounding unit.

Top module: `cap_timebase`

## Requirements
- R1: After reset the count is 0 and neither `match_pls` nor `wrap_pls` is high.
- R2: With `run_en` high, the count advances by one at each prescaled tick. With `run_en` low, the count holds, unless a write, reload or capture clear acts on it. A capture clear or reload acts whatever the state of `run_en`.
- R3: `div_sel` picks the ratio of source ticks per count: 0→1, 1→4, 2→16, 3→32, 4→64, 5→96, 6→112, 7→128. The prescaler phase is held at zero while `run_en` is low.
- R4: `src_sel` picks the tick source: 0 is the system clock (one tick per cycle), 1/2/3 is a rising edge of `cap_in[0]/[1]/[2]`. An input that rises before clock edge k gives a tick in the cycle after edge k+1, so the count changes at edge k+2 at ratio 1.
- R5: With `cmp_en` high, an increment whose result equals `cmp_val` gives `match_pls` high for one cycle. The pulse appears in the same cycle as the updated count.
- R6: With `clr_on_cmp` high, a compare hit loads 0 instead of the incremented value, so the count runs 0..`cmp_val`-1.
- R7: With `clr_on_cap` high, any bit of `cap_evt` set loads 0 into the count.
- R8: With `rld_en` high, the trigger chosen by `rld_sel` loads `cmp_val` into the count. The codes are 000 for `cap_evt[0]`, 001 for `cap_evt[1]`, 010 for `cap_evt[2]` and 100 for a natural wrap. The other codes never reload.
- R9: `wrap_pls` is high for one cycle, with the count already updated, when an increment from 0xFFFFFF is not overruled. It stays low on every reload or clear from a capture event and on every write. A wrap-triggered reload still reports the wrap.
- R10: Precedence in one cycle, from highest to lowest: write, reload, capture clear, compare clear, increment. An overruled increment gives no match pulse.
- R11: `wr_en` loads `wr_data` at the next edge and raises no pulse. It also resets the prescaler phase, so the next count at ratio N comes N source ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Count enable |
| src_sel | input | 2 | Tick source select |
| div_sel | input | 3 | Prescale ratio select |
| cap_in | input | 3 | Raw capture-channel signals usable as tick source |
| cap_evt | input | 3 | Capture-event pulses, one per channel |
| cmp_en | input | 1 | Compare enable |
| clr_on_cmp | input | 1 | Clear count on compare hit |
| clr_on_cap | input | 1 | Clear count on any capture event |
| rld_en | input | 1 | Reload enable |
| rld_sel | input | 3 | Reload trigger select |
| cmp_val | input | 24 | Compare and reload value |
| wr_en | input | 1 | Direct counter write strobe |
| wr_data | input | 24 | Value for a direct write |
| count | output | 24 | Current count |
| match_pls | output | 1 | Compare hit pulse |
| wrap_pls | output | 1 | Overflow pulse |

## Verification
The sharpest collisions are a capture event landing in the same cycle as a natural wrap or a compare hit. In those cycles the reload or capture clear must win, and the wrap and match pulses must vanish. The exception is a wrap-triggered reload, which keeps its wrap pulse. Writes placed near all-ones and near the compare value make the same pile-ups happen under a write. These cycles are provoked by segments that write the counter a few counts below 0xFFFFFF or below `cmp_val` while capture pulses arrive often. A behavioural model applies the precedence list on every clock, and the count and both pulses are compared against it.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int unsigned PRE_W = 7;

  typedef enum logic [2:0] {
    RLD_CAP0 = 3'b000,
    RLD_CAP1 = 3'b001,
    RLD_CAP2 = 3'b010,
    RLD_WRAP = 3'b100
  } rld_code_e;

  // source ticks per count for each divide code
  function automatic logic [PRE_W:0] div_ratio(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd1;
      3'd1:    return 8'd4;
      3'd2:    return 8'd16;
      3'd3:    return 8'd32;
      3'd4:    return 8'd64;
      3'd5:    return 8'd96;
      3'd6:    return 8'd112;
      default: return 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/ctb_edge_src.sv
module ctb_edge_src #(
  parameter int NUM_CH = 3,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic [SRC_W-1:0]  src_sel,
  output logic              src_tick
);
  logic [NUM_CH-1:0] rise_w;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic s1_q, s2_q, s3_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
          s3_q <= 1'b0;
        end else begin
          s1_q <= cap_in[g];
          s2_q <= s1_q;
          s3_q <= s2_q;
        end
      end
      assign rise_w[g] = s2_q & ~s3_q;

      // R4
      edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[g] |=> !rise_w[g]);
    end
  endgenerate

  always_comb begin
    src_tick = (src_sel == '0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (src_sel == SRC_W'(ch + 1)) src_tick = rise_w[ch];
    end
  end
endmodule

// File: rtl/ctb_prescaler.sv
module ctb_prescaler
  import ctb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_en,
  input  logic       phase_rst,
  input  logic [2:0] div_sel,
  input  logic       src_tick,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   ratio_w;
  logic             last_w;

  assign ratio_w = div_ratio(div_sel);
  assign last_w  = ({1'b0, pre_q} >= (ratio_w - 1'b1));
  assign tick    = run_en && !phase_rst && src_tick && last_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pre_q <= '0;
    else if (phase_rst || !run_en) pre_q <= '0;
    else if (src_tick)           pre_q <= last_w ? '0 : pre_q + 1'b1;
  end

  // R3
  back_to_back_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick) && $stable(div_sel)) |-> (div_sel == 3'd0));
endmodule

// File: rtl/ctb_counter.sv
module ctb_counter
  import ctb_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              tick,
  input  logic [NUM_CH-1:0] cap_evt,
  input  logic              cmp_en,
  input  logic              clr_on_cmp,
  input  logic              clr_on_cap,
  input  logic              rld_en,
  input  logic [2:0]        rld_sel,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              match_pls,
  output logic              wrap_pls
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic cap_trig(input logic [2:0] code, input logic [NUM_CH-1:0] ev);
    case (code)
      RLD_CAP0: return ev[0];
      RLD_CAP1: return ev[1];
      RLD_CAP2: return ev[2];
      default:  return 1'b0;
    endcase
  endfunction

  logic [CNT_W-1:0] cnt_q, nat_w, cnt_d;
  logic inc_w, wrap_w, cap_load_w, wrap_load_w, load_w, cap_clr_w, cmp_hit_w, ovf_hit_w;
  logic match_q, wrap_q;

  assign inc_w       = run_en && tick;
  assign nat_w       = cnt_q + 1'b1;
  assign wrap_w      = inc_w && (cnt_q == CNT_MAX);
  assign cap_load_w  = !wr_en && rld_en && cap_trig(rld_sel, cap_evt);
  assign wrap_load_w = !wr_en && rld_en && (rld_sel == RLD_WRAP) && wrap_w;
  assign load_w      = cap_load_w || wrap_load_w;
  assign cap_clr_w   = !wr_en && !load_w && clr_on_cap && (|cap_evt);
  assign cmp_hit_w   = !wr_en && !load_w && !cap_clr_w && cmp_en && inc_w && (nat_w == cmp_val);
  assign ovf_hit_w   = !wr_en && !cap_load_w && !cap_clr_w && wrap_w;

  always_comb begin
    if (wr_en)                         cnt_d = wr_data;
    else if (load_w)                   cnt_d = cmp_val;
    else if (cap_clr_w)                cnt_d = '0;
    else if (cmp_hit_w && clr_on_cmp)  cnt_d = '0;
    else if (inc_w)                    cnt_d = nat_w;
    else                               cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      match_q <= cmp_hit_w;
      wrap_q  <= ovf_hit_w;
    end
  end

  assign count     = cnt_q;
  assign match_pls = match_q;
  assign wrap_pls  = wrap_q;

  // R9
  wrap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pls |-> ($past(count) == CNT_MAX));
  // R5
  match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pls |-> (count == $past(cmp_val) || count == '0));
  // R11
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (count == $past(wr_data)) && !match_pls && !wrap_pls);
  // R8
  reload_cap0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_en && rld_sel == 3'b000 && cap_evt[0] && !wr_en) |=> (count == $past(cmp_val)));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !wr_en && cap_evt == '0) |=> $stable(count));
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase
  import ctb_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int NUM_CH = 3,
  parameter int SRC_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [2:0]        div_sel,
  input  logic [NUM_CH-1:0] cap_in,
  input  logic [NUM_CH-1:0] cap_evt,
  input  logic              cmp_en,
  input  logic              clr_on_cmp,
  input  logic              clr_on_cap,
  input  logic              rld_en,
  input  logic [2:0]        rld_sel,
  input  logic [CNT_W-1:0]  cmp_val,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              match_pls,
  output logic              wrap_pls
);
  logic src_tick_w, tick_w;

  ctb_edge_src #(.NUM_CH(NUM_CH), .SRC_W(SRC_W)) u_src (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .src_sel(src_sel), .src_tick(src_tick_w)
  );

  ctb_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .phase_rst(wr_en),
    .div_sel(div_sel), .src_tick(src_tick_w), .tick(tick_w)
  );

  ctb_counter #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick_w), .cap_evt(cap_evt),
    .cmp_en(cmp_en), .clr_on_cmp(clr_on_cmp), .clr_on_cap(clr_on_cap),
    .rld_en(rld_en), .rld_sel(rld_sel), .cmp_val(cmp_val),
    .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .match_pls(match_pls), .wrap_pls(wrap_pls)
  );
endmodule

// File: tb/cap_timebase_tb.sv
module cap_timebase_tb_top;
  localparam logic [23:0] MAXV = 24'hFFFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 0, cmp_en = 0, clr_on_cmp = 0, clr_on_cap = 0, rld_en = 0, wr_en = 0;
  logic [1:0] src_sel = 0;
  logic [2:0] div_sel = 0, rld_sel = 0, cap_in = 0, cap_evt = 0;
  logic [23:0] cmp_val = 0, wr_data = 0;
  logic [23:0] count;
  logic match_pls, wrap_pls;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel), .div_sel(div_sel),
    .cap_in(cap_in), .cap_evt(cap_evt), .cmp_en(cmp_en), .clr_on_cmp(clr_on_cmp),
    .clr_on_cap(clr_on_cap), .rld_en(rld_en), .rld_sel(rld_sel), .cmp_val(cmp_val),
    .wr_en(wr_en), .wr_data(wr_data), .count(count), .match_pls(match_pls), .wrap_pls(wrap_pls)
  );

  // reference model
  bit [2:0] hist_a, hist_b, hist_c;
  int phase;
  bit [23:0] m_count;
  bit m_match, m_wrap;

  function automatic int ratio_of(input int code);
    int table_v[8] = '{1, 4, 16, 32, 64, 96, 112, 128};
    return table_v[code];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_a = 0; hist_b = 0; hist_c = 0; phase = 0;
      m_count = 0; m_match = 0; m_wrap = 0;
    end else begin
      bit stk, tk, inc, wrap, capld;
      bit [23:0] nxt;
      if (src_sel == 0) stk = 1;
      else stk = hist_b[src_sel-1] && !hist_c[src_sel-1];
      hist_c = hist_b; hist_b = hist_a; hist_a = cap_in;
      tk = 0;
      if (wr_en || !run_en) phase = 0;
      else if (stk) begin
        if (phase + 1 >= ratio_of(div_sel)) begin tk = 1; phase = 0; end
        else phase = phase + 1;
      end
      inc = run_en && tk;
      nxt = m_count + 24'd1;
      wrap = inc && (m_count == MAXV);
      capld = rld_en && ((rld_sel == 0 && cap_evt[0]) || (rld_sel == 1 && cap_evt[1]) ||
                         (rld_sel == 2 && cap_evt[2]));
      m_match = 0; m_wrap = 0;
      if (wr_en) m_count = wr_data;
      else if (capld) m_count = cmp_val;
      else if (rld_en && rld_sel == 4 && wrap) begin m_count = cmp_val; m_wrap = 1; end
      else if (clr_on_cap && cap_evt != 0) m_count = 0;
      else if (inc) begin
        m_wrap = wrap;
        if (cmp_en && nxt == cmp_val) begin
          m_match = 1;
          m_count = clr_on_cmp ? 24'd0 : nxt;
        end else m_count = nxt;
      end
    end
  end

  task automatic check(input string req);
    n_cmp++;
    if (count !== m_count || match_pls !== m_match || wrap_pls !== m_wrap) begin
      n_bad++;
      $display("FAIL %s: count=%h match=%b wrap=%b expected count=%h match=%b wrap=%b",
               req, count, match_pls, wrap_pls, m_count, m_match, m_wrap);
    end
  endtask

  task automatic seg(input string req, input int n, input int ev_rate, input int tog_rate,
                     input int wr_rate);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req);
      cap_evt = 0; wr_en = 0;
      if (ev_rate > 0 && ($urandom % ev_rate) == 0) cap_evt = 3'($urandom);
      if (tog_rate > 0 && ($urandom % tog_rate) == 0) cap_in = cap_in ^ 3'($urandom);
      if (wr_rate > 0 && ($urandom % wr_rate) == 0) begin
        wr_en = 1;
        case ($urandom % 3)
          0: wr_data = cmp_val - 24'(($urandom % 4) + 1);
          1: wr_data = MAXV - 24'($urandom % 4);
          default: wr_data = 24'($urandom % 64);
        endcase
      end
    end
  endtask

  task automatic write_now(input logic [23:0] v);
    @(negedge clk);
    check("R11");
    cap_evt = 0; wr_en = 1; wr_data = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    seg("R1", 3, 0, 0, 0);
    // R2 count and hold
    run_en = 1;
    seg("R2", 20, 0, 0, 0);
    run_en = 0;
    seg("R2", 10, 0, 0, 0);
    run_en = 1;
    seg("R2", 10, 0, 0, 0);
    // R3 every divide ratio
    for (int d = 0; d < 8; d++) begin
      div_sel = 3'(d);
      write_now(24'd0);
      seg("R3", ratio_of(d) * 3 + 5, 0, 0, 0);
    end
    // R4 capture inputs as tick source
    for (int s = 1; s < 4; s++) begin
      src_sel = 2'(s);
      div_sel = 0;
      seg("R4", 80, 0, 3, 0);
      div_sel = 1;
      seg("R4", 80, 0, 3, 0);
    end
    src_sel = 0; div_sel = 0;
    // R5 compare pulse
    cmp_en = 1; cmp_val = 24'd10;
    write_now(24'd0);
    seg("R5", 30, 0, 0, 0);
    // R6 clear on compare
    clr_on_cmp = 1; cmp_val = 24'd5;
    seg("R6", 40, 0, 0, 0);
    clr_on_cmp = 0; cmp_en = 0;
    // R7 clear on capture, running and halted
    clr_on_cap = 1;
    seg("R7", 60, 4, 0, 0);
    run_en = 0;
    write_now(24'h123456);
    seg("R7", 30, 4, 0, 0);
    run_en = 1; clr_on_cap = 0;
    // R8 reload trigger codes, including unused ones
    rld_en = 1; cmp_val = 24'h00ABCD;
    for (int k = 0; k < 8; k++) begin
      rld_sel = 3'(k);
      write_now(MAXV - 24'd3);
      seg("R8", 40, 3, 0, 0);
    end
    rld_en = 0;
    // R9 natural wrap under a divider
    div_sel = 1;
    write_now(MAXV - 24'd5);
    seg("R9", 40, 0, 0, 0);
    div_sel = 0;
    write_now(MAXV - 24'd2);
    seg("R9", 10, 0, 0, 0);
    // R11 write in mid-prescale
    div_sel = 4;
    write_now(24'd0);
    seg("R11", 30, 0, 0, 0);
    write_now(24'd77);
    seg("R11", 140, 0, 0, 0);
    // R10 collisions under random configurations
    for (int blk = 0; blk < 60; blk++) begin
      run_en     = ($urandom % 8) != 0;
      src_sel    = (($urandom % 3) == 0) ? 2'($urandom) : 2'd0;
      div_sel    = (($urandom % 2) == 0) ? 3'd0 : 3'($urandom % 3);
      cmp_en     = 1'($urandom);
      clr_on_cmp = 1'($urandom);
      clr_on_cap = 1'($urandom);
      rld_en     = 1'($urandom);
      rld_sel    = (($urandom % 2) == 0) ? 3'd4 : 3'($urandom);
      cmp_val    = (($urandom % 2) == 0) ? 24'($urandom % 32) : MAXV - 24'($urandom % 8);
      seg("R10", 120, 5, 4, 12);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule